// File: doc/BRIEF.md
# Four-Channel Offset Nulling Sequencer

This controller removes the input offset of four amplifier channels by running four successive-approximation searches side by side. Each channel has a calibration DAC driven from `dac_code` and a comparator that reports on `cmp_pos` whether the leftover offset is still positive. One state machine with a shared bit pointer and a shared settle counter paces all four searches. Each channel keeps its own trial register and its own result register.

A run starts in one of three ways. The first is leaving reset, which counts as power-on and inserts a long supply-settling wait before the search. The second is a rising edge on the asynchronous `cal_pin`. The third is a one-cycle `cal_cmd` strobe from the test port. While a run is active, `clamp` stays high so the analog outputs are held at 0 V. The fall of `clamp` is the only sign that the run has ended. Results sit in volatile flops and are found again on every run. Trigger requests that arrive during a run are dropped.

Top module: `offset_cal_seq`

## Requirements
- R1: `clamp` is high while reset is held. After reset is released it stays high for PWRUP_CYC + CODE_W*(SETTLE_CYC+2) + 1 clock cycles, counted from the release, and then goes low.
- R2: A `cal_cmd` pulse that is sampled high while idle sets `clamp` high at the next clock edge. `clamp` then stays high for exactly CODE_W*(SETTLE_CYC+2) + 1 cycles.
- R3: `cal_pin` passes through a two-flop synchroniser. A rising edge on it while idle sets `clamp` high on the third clock edge after the pin rises, not earlier. The run length is the same as in R2.
- R4: Each search starts at mid-scale (only the MSB set). It settles for SETTLE_CYC cycles per bit and then samples `cmp_pos`. A 1 keeps the bit under test and a 0 clears it. Bits are decided from MSB to LSB. With a comparator that reports 1 exactly when code <= T, the final code is T.
- R5: The four channels are searched at the same time and independently. Channel k uses `cmp_pos[k]` and drives `dac_code[k*CODE_W +: CODE_W]`. Different targets on different channels each give their own result in one run.
- R6: A `cal_cmd` pulse or a `cal_pin` edge that arrives while `clamp` is high is ignored and is not queued. No second run follows.
- R7: While `clamp` is high, `dac_code` shows the trial codes, which are mid-scale in the first cycle of a search. While idle, `dac_code` holds the last results and does not change, whatever `cmp_pos` does.
- R8: Every run recomputes the codes from scratch. A second run with new comparator behaviour produces the new codes.
- R9: Search limits: a target of 0 gives code 0, and a target of all ones gives code all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset, treated as power-on |
| cal_pin | input | 1 | Asynchronous external calibrate request, acts on its rising edge |
| cal_cmd | input | 1 | Single-cycle calibrate strobe from the test port |
| cmp_pos | input | NCH | Per-channel comparator, 1 = residual offset still positive |
| dac_code | output | NCH*CODE_W | Per-channel calibration DAC codes, channel k at bits k*CODE_W upward |
| clamp | output | 1 | Output clamp, high for the whole of a run |

## Verification
A strobe shows on `clamp` one edge later. A pin edge shows three edges later because of the two synchroniser flops and the edge register. The bench samples on the falling edge and checks `clamp` at exactly those edges, and confirms it is still low one edge before. Run length is counted in falling-edge samples with `clamp` high and compared with the closed-form totals of R1 and R2. The final codes are read at the first low sample, because the results load on the same edge that ends the run. A behavioural comparator model that compares the driven code against a target settles combinationally within that half cycle.

// File: rtl/offset_cal_seq.sv
module offset_cal_seq #(
  parameter int NCH        = 4,
  parameter int CODE_W     = 8,
  parameter int SETTLE_CYC = 1000,
  parameter int PWRUP_CYC  = 20_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cal_pin,
  input  logic                    cal_cmd,
  input  logic [NCH-1:0]          cmp_pos,
  output logic [NCH*CODE_W-1:0]   dac_code,
  output logic                    clamp
);

  localparam int CNT_MAX = (PWRUP_CYC > SETTLE_CYC) ? PWRUP_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [BIT_W-1:0]  TOP_BIT  = BIT_W'(CODE_W - 1);
  localparam logic [CODE_W-1:0] MID      = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CNT_W-1:0]  PW_LAST  = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0]  ST_LAST  = CNT_W'(SETTLE_CYC - 1);

  typedef enum logic [2:0] {IDLE, POWERUP_WAIT, SETTLE, SAMPLE, NEXT_BIT, DONE} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [2:0]        pin_q;
  logic              trig, start, pw_end, st_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[1:0], cal_pin};

  assign trig   = (pin_q[1] & ~pin_q[2]) | cal_cmd;
  assign pw_end = (state == POWERUP_WAIT) && (cnt == PW_LAST);
  assign st_end = (state == SETTLE) && (cnt == ST_LAST);
  assign start  = ((state == IDLE) && trig) || pw_end;
  assign clamp  = (state != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= POWERUP_WAIT;
      cnt     <= '0;
      bit_idx <= TOP_BIT;
    end else begin
      case (state)
        IDLE: if (trig) begin
          state   <= SETTLE;
          cnt     <= '0;
          bit_idx <= TOP_BIT;
        end
        POWERUP_WAIT: if (pw_end) begin
          state   <= SETTLE;
          cnt     <= '0;
          bit_idx <= TOP_BIT;
        end else cnt <= cnt + 1'b1;
        SETTLE: if (st_end) begin
          state <= SAMPLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        SAMPLE: state <= NEXT_BIT;
        NEXT_BIT: if (bit_idx == '0) state <= DONE;
        else begin
          bit_idx <= bit_idx - 1'b1;
          state   <= SETTLE;
        end
        DONE: state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] trial_r, result_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trial_r  <= MID;
        result_r <= '0;
      end else if (start) begin
        trial_r <= MID;
      end else if (state == SAMPLE) begin
        if (!cmp_pos[g]) trial_r[bit_idx] <= 1'b0;
      end else if (state == NEXT_BIT && bit_idx != '0) begin
        trial_r[bit_idx - 1'b1] <= 1'b1;
      end else if (state == DONE) begin
        result_r <= trial_r;
      end
    end

    assign dac_code[g*CODE_W +: CODE_W] = clamp ? trial_r : result_r;

    // R4
    sar_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SAMPLE) |=> (trial_r[$past(bit_idx)] == $past(cmp_pos[g])));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == IDLE && !trig) |=> $stable(dac_code[g*CODE_W +: CODE_W]));
  end

  // R2
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && trig) |=> (clamp && state == SETTLE && bit_idx == TOP_BIT));

  // R6
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SETTLE && bit_idx != TOP_BIT) |=> (bit_idx != TOP_BIT));

  // R1
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == NEXT_BIT && bit_idx == '0) |=> ##1 !clamp);

endmodule

// File: tb/offset_cal_seq_tb.sv
module offset_cal_seq_tb;
  localparam int NCH = 4, W = 8, ST = 4, PW = 20;
  localparam int RUN = W * (ST + 2) + 1;

  logic clk = 0, rst_n = 0, cal_pin = 0, cal_cmd = 0;
  logic [NCH-1:0] cmp_pos;
  logic [NCH*W-1:0] dac_code;
  logic clamp;
  logic [W-1:0] tgt [NCH];
  int n_run = 0, n_fail = 0;
  bit fin = 0;

  always #5 clk = ~clk;

  offset_cal_seq #(.NCH(NCH), .CODE_W(W), .SETTLE_CYC(ST), .PWRUP_CYC(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_pin(cal_pin), .cal_cmd(cal_cmd),
    .cmp_pos(cmp_pos), .dac_code(dac_code), .clamp(clamp));

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    assign cmp_pos[k] = (dac_code[k*W +: W] <= tgt[k]);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_tgt(input int a, input int b, input int c, input int d);
    tgt[0] = W'(a); tgt[1] = W'(b); tgt[2] = W'(c); tgt[3] = W'(d);
  endtask

  task automatic count_run(input string req, input int exp);
    int n = 0;
    while (clamp && n < 10000) begin n++; @(negedge clk); end
    chk(req, n, exp);
  endtask

  task automatic chk_codes(input string req);
    for (int k = 0; k < NCH; k++) chk(req, int'(dac_code[k*W +: W]), int'(tgt[k]));
  endtask

  task automatic t_powerup;
    set_tgt(8'h00, 8'hFF, 8'h5A, 8'h81);
    @(negedge clk);
    chk("R1 clamp in reset", clamp, 1);
    rst_n = 1;
    count_run("R1 power-on run length", PW + RUN);
    chk_codes("R9/R5/R4 power-on codes");
  endtask

  task automatic t_cmd;
    set_tgt(8'h33, 8'hC4, 8'h10, 8'hEF);
    repeat (3) @(negedge clk);
    cal_cmd = 1;
    @(negedge clk);
    cal_cmd = 0;
    chk("R2 clamp next edge", clamp, 1);
    for (int k = 0; k < NCH; k++) chk("R7 mid-scale trial", int'(dac_code[k*W +: W]), 8'h80);
    count_run("R2 command run length", RUN);
    chk_codes("R8/R5 recomputed codes");
  endtask

  task automatic t_pin;
    set_tgt(8'h01, 8'h80, 8'h7F, 8'hFE);
    repeat (2) @(negedge clk);
    cal_pin = 1;
    @(negedge clk);
    chk("R3 not after 1 edge", clamp, 0);
    @(negedge clk);
    chk("R3 not after 2 edges", clamp, 0);
    @(negedge clk);
    chk("R3 clamp after 3 edges", clamp, 1);
    count_run("R3 pin run length", RUN);
    chk_codes("R4 pin run codes");
    cal_pin = 0;
  endtask

  task automatic t_retrig;
    int extra = 0;
    set_tgt(8'hA5, 8'h3C, 8'h00, 8'hFF);
    repeat (4) @(negedge clk);
    cal_cmd = 1;
    @(negedge clk);
    cal_cmd = 0;
    repeat (10) @(negedge clk);
    cal_cmd = 1;
    @(negedge clk);
    cal_cmd = 0;
    cal_pin = 1;
    repeat (20) @(negedge clk);
    cal_cmd = 1;
    @(negedge clk);
    cal_cmd = 0;
    count_run("R6 length unchanged", RUN - 32);
    chk_codes("R6 codes");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (clamp) extra++;
    end
    chk("R6 no queued run", extra, 0);
    cal_pin = 0;
  endtask

  task automatic t_idle_hold;
    logic [NCH*W-1:0] held;
    held = dac_code;
    set_tgt(8'h11, 8'h22, 8'h33, 8'h44);
    repeat (8) @(negedge clk);
    chk("R7 idle code hold", int'(dac_code == held), 1);
    chk("R7 clamp low in idle", clamp, 0);
  endtask

  initial begin
    #2_000_000;
    if (!fin) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_powerup();
    t_cmd();
    t_pin();
    t_retrig();
    t_idle_hold();
    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule